// File: doc/BRIEF.md
# UDP/IPv4 Frame Transmitter with Byte-Wide Media Interface

This block turns a buffered payload into a complete Ethernet II frame that carries an IPv4 datagram with a UDP segment. It drives the frame one byte per clock on a GMII-style transmit pair, a data byte and an enable. Frames go out on a fixed schedule: an idle counter runs until it reaches a programmed period. The block then captures the payload length and computes the IPv4 header checksum. It waits until the payload store reports ready, then streams the frame and its CRC-32 frame check sequence and goes back to idle.

MAC addresses, IP addresses and UDP ports come from static configuration inputs. Payload bytes are fetched through a combinational read port: the block presents a byte index and takes the byte back in the same cycle. Payloads shorter than the Ethernet minimum are padded with zero bytes. PHY management, receive, ARP and memory control belong to other blocks.

Top module: `udp_tx_gmii`

## Requirements
- R1: While reset is asserted, and right after it, tx_en is 0, txd is 0x00 and pay_idx is 0.
- R2: The idle counter leaves idle when it reaches PERIOD (PERIOD must be at least 12). With buf_ready held high, exactly PERIOD+3 cycles with tx_en low separate the last byte of one frame from the first byte of the next.
- R3: After the header checksum step, no byte is sent while buf_ready is low. The first preamble byte appears on the second clock edge after buf_ready is seen high.
- R4: Every frame opens with seven bytes of 0x55 followed by one 0xD5.
- R5: After the preamble come the destination MAC, then the source MAC (each most significant byte first), then the EtherType 0x0800.
- R6: The 20-byte IPv4 header is, in order: 0x45, 0x00, total length 28+L, identification 0x0000, flags/fragment 0x0000, TTL 0x40, protocol 0x11, header checksum, source IP, destination IP. All multi-byte fields are big-endian. The ones-complement sum of its ten 16-bit words is 0xFFFF.
- R7: The 8-byte UDP header is source port, destination port, length 8+L and checksum 0x0000, all big-endian.
- R8: Payload byte k (0 ≤ k < L) is the byte read at pay_idx = k, sent in increasing k. When L < 18, zero bytes follow the payload so that exactly 18 body bytes are sent.
- R9: The last four bytes are the CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion) over the bytes from the destination MAC through the last body byte. They are sent least significant byte first.
- R10: tx_en stays high without a break from the first preamble byte through the last FCS byte, for 8+42+max(L,18)+4 cycles, and is low at all other times.
- R11: pay_len is sampled once per frame, at the checksum step. A change to it while the block waits for buf_ready has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_ready | input | 1 | Payload store holds a complete payload |
| pay_len | input | LEN_W | Payload length L in bytes |
| pay_idx | output | LEN_W | Index of the payload byte being read |
| pay_byte | input | 8 | Payload byte at pay_idx, same cycle |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | UDP source port |
| dst_port | input | 16 | UDP destination port |
| txd | output | 8 | Transmit data byte |
| tx_en | output | 1 | Transmit enable |

## Verification
The bench sends payloads of 0, 1, 17, 18, 19 and 40 bytes, so it covers the padding boundary on both sides. A design that pads one byte too few or too many shifts the FCS and changes the enable length, and both checks catch it. Each frame is compared byte by byte with a frame the bench builds itself, including its own CRC and header checksum. A wrong byte order in the FCS, or a checksum computed over the wrong words, shows up as a byte mismatch. The bench holds buf_ready low across the checksum step and changes pay_len during that wait. A design that does not gate on buf_ready starts early, and one that reads the length late sends the wrong length fields and body size.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_WAIT,
      ST_PRE,
      ST_HDR,
      ST_PAY,
      ST_FCS
   } tx_state_t;

   localparam int PRE_BYTES = 8;
   localparam int HDR_BYTES = 42;
   localparam int MIN_BODY  = 18;
   localparam int FCS_BYTES = 4;
   localparam int IP_UDP_HDR = 28;
   localparam int UDP_HDR   = 8;

   function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
      logic [31:0] c;
      c = c_in ^ {24'h0, d};
      for (int b = 0; b < 8; b++) begin
         c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/udp_tx_timer.sv
module udp_tx_timer #(
   parameter int unsigned         TMR_W  = 32,
   parameter logic [TMR_W-1:0]    PERIOD = 32'h00400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   logic [TMR_W-1:0] tcount;

   assign hit = run && (tcount == PERIOD);

   always_ff @(posedge clk) begin
      if (!rst_n)              tcount <= '0;
      else if (!run || hit)    tcount <= '0;
      else                     tcount <= tcount + 1'b1;
   end
endmodule

// File: rtl/udp_tx_csum.sv
module udp_tx_csum (
   input  logic [15:0] total_len,
   input  logic [31:0] src_ip,
   input  logic [31:0] dst_ip,
   output logic [15:0] csum
);
   logic [31:0] acc;
   logic [16:0] fold1;
   logic [15:0] fold2;

   always_comb begin
      acc = 32'h0000_4500 + {16'h0, total_len} + 32'h0000_4011
          + {16'h0, src_ip[31:16]} + {16'h0, src_ip[15:0]}
          + {16'h0, dst_ip[31:16]} + {16'h0, dst_ip[15:0]};
      fold1 = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
      fold2 = fold1[15:0] + {15'h0, fold1[16]};
      csum  = ~fold2;
   end
endmodule

// File: rtl/udp_tx_crc.sv
module udp_tx_crc
   import udp_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  data,
   output logic [31:0] crc
);
   always_ff @(posedge clk) begin
      if (!rst_n || init) crc <= 32'hFFFF_FFFF;
      else if (en)        crc <= crc32_step(crc, data);
   end

   assert_crc_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (crc == 32'hFFFF_FFFF));
endmodule

// File: rtl/udp_tx_gmii.sv
module udp_tx_gmii
   import udp_tx_pkg::*;
#(
   parameter int unsigned      LEN_W  = 11,
   parameter int unsigned      TMR_W  = 32,
   parameter logic [TMR_W-1:0] PERIOD = 32'h00400000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_ready,
   input  logic [LEN_W-1:0] pay_len,
   output logic [LEN_W-1:0] pay_idx,
   input  logic [7:0]       pay_byte,
   input  logic [47:0]      dst_mac,
   input  logic [47:0]      src_mac,
   input  logic [31:0]      src_ip,
   input  logic [31:0]      dst_ip,
   input  logic [15:0]      src_port,
   input  logic [15:0]      dst_port,
   output logic [7:0]       txd,
   output logic             tx_en
);
   localparam int CNT_W    = (LEN_W > 6) ? LEN_W : 6;
   localparam int HDR_BITS = HDR_BYTES * 8;

   if (PERIOD < 12) begin : g_bad_period
      $error("PERIOD must leave at least 12 idle byte times");
   end
   if (LEN_W < 5 || LEN_W > 15) begin : g_bad_len
      $error("LEN_W must lie between 5 and 15");
   end

   tx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;
   logic [15:0]      csum_q, csum_c;
   logic [15:0]      ip_len, udp_len;
   logic [31:0]      crc_q, fcs;
   logic [7:0]       cur_byte;
   logic             cur_en, timer_hit;
   logic [CNT_W-1:0] body_last;
   logic [HDR_BITS-1:0] hdr;

   udp_tx_timer #(.TMR_W(TMR_W), .PERIOD(PERIOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE), .hit(timer_hit));

   udp_tx_csum u_csum (
      .total_len(16'(pay_len) + 16'(IP_UDP_HDR)),
      .src_ip(src_ip), .dst_ip(dst_ip), .csum(csum_c));

   udp_tx_crc u_crc (
      .clk(clk), .rst_n(rst_n), .init(state == ST_PRE),
      .en(state == ST_HDR || state == ST_PAY), .data(cur_byte), .crc(crc_q));

   assign ip_len    = 16'(len_q) + 16'(IP_UDP_HDR);
   assign udp_len   = 16'(len_q) + 16'(UDP_HDR);
   assign fcs       = ~crc_q;
   assign body_last = (CNT_W'(len_q) < CNT_W'(MIN_BODY)) ? CNT_W'(MIN_BODY - 1)
                                                          : CNT_W'(len_q) - 1'b1;
   assign hdr = {dst_mac, src_mac, 16'h0800,
                 8'h45, 8'h00, ip_len, 16'h0000, 16'h0000, 8'h40, 8'h11, csum_q,
                 src_ip, dst_ip,
                 src_port, dst_port, udp_len, 16'h0000};
   assign pay_idx = (state == ST_PAY) ? cnt[LEN_W-1:0] : '0;

   always_comb begin
      cur_byte = 8'h00;
      cur_en   = 1'b0;
      case (state)
         ST_PRE: begin
            cur_en   = 1'b1;
            cur_byte = (cnt == CNT_W'(PRE_BYTES - 1)) ? 8'hD5 : 8'h55;
         end
         ST_HDR: begin
            cur_en   = 1'b1;
            cur_byte = hdr[HDR_BITS - 1 - 8 * int'(cnt) -: 8];
         end
         ST_PAY: begin
            cur_en   = 1'b1;
            cur_byte = (cnt < CNT_W'(len_q)) ? pay_byte : 8'h00;
         end
         ST_FCS: begin
            cur_en   = 1'b1;
            cur_byte = fcs[8 * int'(cnt[1:0]) +: 8];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         len_q  <= '0;
         csum_q <= '0;
         txd    <= 8'h00;
         tx_en  <= 1'b0;
      end else begin
         txd   <= cur_byte;
         tx_en <= cur_en;
         case (state)
            ST_IDLE:  if (timer_hit) state <= ST_START;
            ST_START: begin
               len_q  <= pay_len;
               csum_q <= csum_c;
               state  <= ST_WAIT;
            end
            ST_WAIT: if (buf_ready) begin
               state <= ST_PRE;
               cnt   <= '0;
            end
            ST_PRE: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(PRE_BYTES - 1)) begin
                  state <= ST_HDR;
                  cnt   <= '0;
               end
            end
            ST_HDR: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(HDR_BYTES - 1)) begin
                  state <= ST_PAY;
                  cnt   <= '0;
               end
            end
            ST_PAY: begin
               cnt <= cnt + 1'b1;
               if (cnt == body_last) begin
                  state <= ST_FCS;
                  cnt   <= '0;
               end
            end
            ST_FCS: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(FCS_BYTES - 1)) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // run of low enable cycles, saturating, for the gap check
   logic [3:0] low_run;
   always_ff @(posedge clk) begin
      if (!rst_n)               low_run <= 4'hF;
      else if (tx_en)           low_run <= 4'h0;
      else if (low_run != 4'hF) low_run <= low_run + 1'b1;
   end

   assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> (low_run >= 4'd12));

   assert_wait_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE && $past(state) == ST_WAIT) |-> $past(buf_ready));

   assert_pre_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> (txd == 8'h55));

   assert_en_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> ($past(state) == ST_IDLE));

   assert_len_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) != ST_IDLE && $past(state) != ST_START) |-> $stable(len_q));
endmodule

// File: tb/tb_udp_tx_gmii.sv
module tb_udp_tx_gmii;
   localparam int P  = 20;
   localparam int LW = 11;
   // vector: [31:16] dst port, [15:8] payload seed, [7:0] payload length
   localparam logic [31:0] VEC [0:5] = '{
      32'h1001_1000, 32'h1002_2001, 32'h1003_3011,
      32'h1004_4012, 32'h1005_5013, 32'h1006_6028 };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, buf_ready, tx_en;
   logic [LW-1:0] pay_len, pay_idx;
   logic [7:0]    pay_byte, txd, seed;
   logic [47:0]   dst_mac = 48'h02_11_22_33_44_55;
   logic [47:0]   src_mac = 48'h02_AA_BB_CC_DD_EE;
   logic [31:0]   src_ip  = 32'hC0A8_0A01;
   logic [31:0]   dst_ip  = 32'hC0A8_0A64;
   logic [15:0]   src_port = 16'd5000;
   logic [15:0]   dst_port;

   udp_tx_gmii #(.LEN_W(LW), .TMR_W(32), .PERIOD(32'(P))) dut (
      .clk(clk), .rst_n(rst_n), .buf_ready(buf_ready), .pay_len(pay_len),
      .pay_idx(pay_idx), .pay_byte(pay_byte), .dst_mac(dst_mac), .src_mac(src_mac),
      .src_ip(src_ip), .dst_ip(dst_ip), .src_port(src_port), .dst_port(dst_port),
      .txd(txd), .tx_en(tx_en));

   assign pay_byte = seed + pay_idx[7:0];

   int total = 0, bad = 0;
   logic [7:0] frm [0:255];
   logic [7:0] ex  [0:255];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] crc_add(input logic [31:0] c_in, input logic [7:0] d);
      logic [31:0] c;
      c = c_in;
      for (int b = 0; b < 8; b++) begin
         if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB88320;
         else             c = c >> 1;
      end
      return c;
   endfunction

   task automatic put16(inout int p, input logic [15:0] v);
      ex[p] = v[15:8]; ex[p+1] = v[7:0]; p += 2;
   endtask

   task automatic build(input int len, input logic [7:0] sd, input logic [15:0] dp, output int n);
      int p;
      int body;
      logic [31:0] s, c;
      p = 0;
      for (int i = 0; i < 7; i++) ex[p++] = 8'h55;
      ex[p++] = 8'hD5;
      for (int i = 5; i >= 0; i--) ex[p++] = dst_mac[8*i +: 8];
      for (int i = 5; i >= 0; i--) ex[p++] = src_mac[8*i +: 8];
      put16(p, 16'h0800);
      s = 32'h4500 + 32'(len + 28) + 32'h4011 + 32'(src_ip[31:16]) + 32'(src_ip[15:0])
        + 32'(dst_ip[31:16]) + 32'(dst_ip[15:0]);
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      put16(p, 16'h4500); put16(p, 16'(len + 28)); put16(p, 16'h0); put16(p, 16'h0);
      put16(p, 16'h4011); put16(p, ~s[15:0]);
      put16(p, src_ip[31:16]); put16(p, src_ip[15:0]);
      put16(p, dst_ip[31:16]); put16(p, dst_ip[15:0]);
      put16(p, src_port); put16(p, dp); put16(p, 16'(len + 8)); put16(p, 16'h0);
      body = (len < 18) ? 18 : len;
      for (int k = 0; k < body; k++) ex[p++] = (k < len) ? sd + 8'(k) : 8'h00;
      c = 32'hFFFF_FFFF;
      for (int i = 8; i < p; i++) c = crc_add(c, ex[i]);
      c = ~c;
      for (int i = 0; i < 4; i++) ex[p++] = c[8*i +: 8];
      n = p;
   endtask

   function automatic string region(input int i, input int n);
      if (i < 8)      return "R4 preamble";
      if (i < 22)     return "R5 mac/ethertype";
      if (i < 42)     return "R6 ipv4 header";
      if (i < 50)     return "R7 udp header";
      if (i < n - 4)  return "R8 payload/pad";
      return "R9 fcs";
   endfunction

   task automatic grab(output int n, output int gap);
      gap = 0;
      while (!tx_en) begin gap++; @(negedge clk); end
      n = 0;
      while (tx_en) begin
         if (n < 256) frm[n] = txd;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic compare(input int len, input logic [7:0] sd, input logic [15:0] dp,
                          input int got, input string tag);
      int n;
      logic [31:0] s;
      build(len, sd, dp, n);
      chk(got == n, {tag, " R10 enable length"}, got, n);
      if (got == n) begin
         for (int i = 0; i < n; i++)
            chk(frm[i] == ex[i], {tag, " ", region(i, n)}, int'(frm[i]), int'(ex[i]));
         s = 0;
         for (int w = 0; w < 10; w++) s += {16'h0, frm[22+2*w], frm[23+2*w]};
         s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
         s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
         chk(s[15:0] == 16'hFFFF, {tag, " R6 header sum"}, int'(s[15:0]), 16'hFFFF);
      end
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, gap;
      bit quiet;
      rst_n = 1'b0; buf_ready = 1'b1;
      pay_len = LW'(VEC[0][7:0]); seed = VEC[0][15:8]; dst_port = VEC[0][31:16];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_en == 1'b0, "R1 tx_en in reset", int'(tx_en), 0);
      chk(txd == 8'h00, "R1 txd in reset", int'(txd), 0);
      chk(pay_idx == '0, "R1 pay_idx in reset", int'(pay_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_en == 1'b0 && txd == 8'h00, "R1 after release", int'(tx_en), 0);

      // table walk
      grab(n, gap);
      compare(int'(VEC[0][7:0]), VEC[0][15:8], VEC[0][31:16], n, "vec0");
      for (int i = 1; i < 6; i++) begin
         pay_len = LW'(VEC[i][7:0]); seed = VEC[i][15:8]; dst_port = VEC[i][31:16];
         grab(n, gap);
         chk(gap == P + 3, "R2 inter-frame gap", gap, P + 3);
         compare(int'(VEC[i][7:0]), VEC[i][15:8], VEC[i][31:16], n, $sformatf("vec%0d", i));
      end

      // R3 gating and R11 length capture
      pay_len = LW'(5); seed = 8'h80; dst_port = 16'h0007; buf_ready = 1'b0;
      quiet = 1'b1;
      for (int c = 0; c < P + 20; c++) begin
         if (c == P + 10) pay_len = LW'(30);
         if (tx_en) quiet = 1'b0;
         @(negedge clk);
      end
      chk(quiet, "R3 silent while buffer not ready", int'(quiet), 1);
      buf_ready = 1'b1;
      @(negedge clk);
      chk(tx_en == 1'b0, "R3 one edge after ready", int'(tx_en), 0);
      @(negedge clk);
      chk(tx_en == 1'b1 && txd == 8'h55, "R3 start two edges after ready", int'(txd), 8'h55);
      grab(n, gap);
      compare(5, 8'h80, 16'h0007, n, "R11 late length change");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule